// File: doc/BRIEF.md
# Data-processing ALU with condition flags

This block is the arithmetic-logic stage of a small load-store RISC core. Each cycle it takes a 4-bit operation code, a first operand read from the register file, and a second operand that an upstream shifter has already prepared. It also takes the current carry flag, the shifter's carry-out and a request to update the flags. From these it forms a 32-bit result and a write-enable for the destination register. Both are combinational.

Beside the datapath sits a four-bit condition register holding negative, zero, carry and overflow. It loads on the clock edge when the instruction asks for a flag update. Four compare/test codes always load it and never write a destination register.

Subtraction treats carry as the inverse of a borrow: a set carry flag means "no borrow". Reverse forms subtract the first operand from the second. Arithmetic codes take their carry and overflow flags from the adder. Logical codes take carry from the shifter and leave overflow as it was.

Top module: `dp_alu`

## Requirements
- R1: Code 4 gives a + b, and code 5 gives a + b + cin (cin is the carry input). Both assert `rd_we`.
- R2: Code 2 gives a - b, and code 6 gives a - b - 1 + cin, so cin=1 means no borrow. Both assert `rd_we`.
- R3: Code 3 gives b - a, and code 7 gives b - a - 1 + cin. Both assert `rd_we`.
- R4: Code 0 gives a AND b, code 1 gives a XOR b, code 12 gives a OR b, and code 14 gives a AND NOT b. All four assert `rd_we`.
- R5: Code 13 passes b through unchanged, and code 15 gives NOT b. Both assert `rd_we`.
- R6: Codes 8 (a AND b), 9 (a XOR b), 10 (a - b) and 11 (a + b) drive that value on `result`, hold `rd_we` low, and load the flags even when `set_flags` is low.
- R7: When `set_flags` is low and the code is not in 8..11, the flag register keeps its value across the edge.
- R8: After an update, flag N (`flags_nzcv[3]`) equals bit 31 of the result, and flag Z (`flags_nzcv[2]`) is set exactly when all 32 result bits are zero.
- R9: For codes 2-7, 10 and 11, flag C (`flags_nzcv[1]`) is the carry-out of the 33-bit sum a + ~b + cin or a + b + cin, which means "no borrow" for subtraction. Flag V (`flags_nzcv[0]`) is set on signed two's-complement overflow.
- R10: For codes 0, 1, 8, 9 and 12-15, an update loads C from `shift_c_out` and leaves V unchanged.
- R11: A synchronous reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Operation code (0..15) |
| opnd_a | input | 32 | First operand, from the register file |
| opnd_b | input | 32 | Second operand, already shifted |
| c_flag_in | input | 1 | Current carry flag, used by codes 5, 6 and 7 |
| shift_c_out | input | 1 | Shifter carry-out, loaded as C by logical codes |
| set_flags | input | 1 | Request to load the flags on this edge |
| result | output | 32 | Combinational result |
| rd_we | output | 1 | Destination-register write enable |
| flags_nzcv | output | 4 | Registered flags: N, Z, C, V from bit 3 down to bit 0 |

## Verification
The result and write-enable are combinational, so an operand-select or opcode-decode fault shows on `result` in the same cycle as the stimulus. A fault in the flag register or its load enable shows on `flags_nzcv` one edge later. A lost hold, a wrongly kept overflow bit or a carry taken from the wrong source can also stay hidden until a later instruction that does not update the flags, so the stimulus alternates updating and non-updating codes. The reference model is therefore compared against the flags after every edge.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_compare(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] op2,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);
  localparam int EW = W + 1;

  logic [W-1:0]  a_sel, b_sel;
  logic          cin_sel;
  logic [EW-1:0] sum_ext;

  // Subtraction is addition of the inverted operand plus a carry-in.
  always_comb begin
    a_sel   = rn;
    b_sel   = op2;
    cin_sel = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin b_sel = ~op2; cin_sel = 1'b1;     end
      OP_SBC:         begin b_sel = ~op2; cin_sel = carry_in; end
      OP_RSB:         begin a_sel = op2; b_sel = ~rn; cin_sel = 1'b1;     end
      OP_RSC:         begin a_sel = op2; b_sel = ~rn; cin_sel = carry_in; end
      OP_ADC:         cin_sel = carry_in;
      default:        ;
    endcase
  end

  assign sum_ext = {1'b0, a_sel} + {1'b0, b_sel} + {{W{1'b0}}, cin_sel};
  assign sum     = sum_ext[W-1:0];
  assign c_out   = sum_ext[W];
  assign v_out   = (a_sel[W-1] == b_sel[W-1]) && (sum_ext[W-1] != a_sel[W-1]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] op2,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = rn & op2;
      OP_EOR, OP_TEQ: res = rn ^ op2;
      OP_ORR:         res = rn | op2;
      OP_BIC:         res = rn & ~op2;
      OP_MOV:         res = op2;
      OP_MVN:         res = ~op2;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         arith,
  input  logic [W-1:0] res,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         shift_c,
  output nzcv_t        flags_q
);
  nzcv_t flags_d;

  always_comb begin
    flags_d.n = res[W-1];
    flags_d.z = (res == '0);
    flags_d.c = arith ? add_c : shift_c;
    flags_d.v = arith ? add_v : flags_q.v;
  end

  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '0;
    else if (load) flags_q <= flags_d;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         c_flag_in,
  input  logic         shift_c_out,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         rd_we,
  output logic [3:0]   flags_nzcv
);
  alu_op_e      op;
  logic         arith, cmp_only;
  logic [W-1:0] add_res, log_res;
  logic         add_c, add_v;
  nzcv_t        flags_q;

  assign op       = alu_op_e'(op_code);
  assign arith    = op_is_arith(op);
  assign cmp_only = op_is_compare(op);

  dp_alu_addsub #(.W(W)) u_addsub (
    .op(op), .rn(opnd_a), .op2(opnd_b), .carry_in(c_flag_in),
    .sum(add_res), .c_out(add_c), .v_out(add_v)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .op(op), .rn(opnd_a), .op2(opnd_b), .res(log_res)
  );

  assign result = arith ? add_res : log_res;
  assign rd_we  = !cmp_only;

  dp_alu_flagreg #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .load(set_flags || cmp_only), .arith(arith),
    .res(result), .add_c(add_c), .add_v(add_v), .shift_c(shift_c_out),
    .flags_q(flags_q)
  );

  assign flags_nzcv = flags_q;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         c_flag_in,
  input logic         shift_c_out,
  input logic         set_flags,
  input logic [W-1:0] result,
  input logic         rd_we,
  input logic [3:0]   flags_nzcv
);
  logic is_cmp, is_logic, upd;
  assign is_cmp   = (op_code[3:2] == 2'b10);
  assign is_logic = (op_code inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});
  assign upd      = set_flags || is_cmp;

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    is_cmp |-> !rd_we);

  assert_cmp_loads_z_R6: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> flags_nzcv[2] == ($past(result) == '0));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags_nzcv));

  assert_n_from_result_R8: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags_nzcv[3] == $past(result[W-1]));

  assert_logic_c_R10: assert property (@(posedge clk) disable iff (rst)
    (upd && is_logic) |=> flags_nzcv[1] == $past(shift_c_out));

  assert_logic_keeps_v_R10: assert property (@(posedge clk) disable iff (rst)
    (upd && is_logic) |=> flags_nzcv[0] == $past(flags_nzcv[0]));

  assert_mov_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd13) |-> result == opnd_b);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> flags_nzcv == 4'b0000);
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .c_flag_in(c_flag_in), .shift_c_out(shift_c_out), .set_flags(set_flags),
  .result(result), .rd_we(rd_we), .flags_nzcv(flags_nzcv)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        c_flag_in = 1'b0, shift_c_out = 1'b0, set_flags = 1'b0;
  logic [31:0] result;
  logic        rd_we;
  logic [3:0]  flags_nzcv;

  int errors = 0;
  int checks = 0;
  logic [3:0] model_flags = 4'b0000;

  always #10 clk = ~clk;  // 50 MHz

  dp_alu u_dp_alu (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .c_flag_in(c_flag_in), .shift_c_out(shift_c_out), .set_flags(set_flags),
    .result(result), .rd_we(rd_we), .flags_nzcv(flags_nzcv)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd4, 4'd5:                 return "R1";
      4'd2, 4'd6:                 return "R2";
      4'd3, 4'd7:                 return "R3";
      4'd0, 4'd1, 4'd12, 4'd14:   return "R4";
      4'd13, 4'd15:               return "R5";
      default:                    return "R6";
    endcase
  endfunction

  // Behavioural reference: exact integer arithmetic on wide signed values.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic cin, input logic sc, input logic [3:0] fold,
                       output logic [31:0] r, output logic we, output logic [3:0] fl);
    longint ua, ub, sa, sb, u, s;
    logic is_ar;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    is_ar = 1'b1; u = 0; s = 0; r = '0;
    case (op)
      4'd4, 4'd11: begin u = ua + ub;            s = sa + sb;            end
      4'd5:        begin u = ua + ub + cin;      s = sa + sb + cin;      end
      4'd2, 4'd10: begin u = ua - ub;            s = sa - sb;            end
      4'd6:        begin u = ua - ub - 1 + cin;  s = sa - sb - 1 + cin;  end
      4'd3:        begin u = ub - ua;            s = sb - sa;            end
      4'd7:        begin u = ub - ua - 1 + cin;  s = sb - sa - 1 + cin;  end
      default: begin
        is_ar = 1'b0;
        case (op)
          4'd0, 4'd8: r = a & b;
          4'd1, 4'd9: r = a ^ b;
          4'd12:      r = a | b;
          4'd14:      r = a & ~b;
          4'd13:      r = b;
          default:    r = ~b;
        endcase
      end
    endcase
    if (is_ar) r = u[31:0];
    we = !(op inside {4'd8, 4'd9, 4'd10, 4'd11});
    fl[3] = r[31];
    fl[2] = (r == 32'd0);
    if (is_ar) begin
      if (op inside {4'd4, 4'd5, 4'd11}) fl[1] = (u > 64'sd4294967295);
      else                              fl[1] = (u >= 0);
      fl[0] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      fl[1] = sc;
      fl[0] = fold[0];
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic cin, input logic sc, input logic sf);
    logic [31:0] r;
    logic we;
    logic [3:0] fl;
    string rq;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; c_flag_in = cin; shift_c_out = sc; set_flags = sf;
    model(op, a, b, cin, sc, model_flags, r, we, fl);
    rq = req_of(op);
    #2;
    check(rq, "result", result, r);
    check(rq, "rd_we", {31'd0, rd_we}, {31'd0, we});
    @(posedge clk);
    if (sf || !we) model_flags = fl;
    #1;
    // R7 hold, R8 N/Z, R9 arithmetic C/V, R10 logical C/V
    check((sf || !we) ? "R8/R9/R10" : "R7", "flags", {28'd0, flags_nzcv}, {28'd0, model_flags});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R11", "reset flags", {28'd0, flags_nzcv}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R1: signed overflow, then unsigned wrap to zero
    step(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
    step(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
    step(4'd5, 32'h10, 32'h20, 1'b1, 1'b0, 1'b1);
    // R10: logical code keeps V, takes C from shifter
    step(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
    step(4'd0, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1'b0, 1'b1, 1'b1);
    // R2: equal subtract, borrow, and SBC with borrow pending
    step(4'd2, 32'd5, 32'd5, 1'b0, 1'b0, 1'b1);
    step(4'd2, 32'd0, 32'd1, 1'b0, 1'b0, 1'b1);
    step(4'd6, 32'd5, 32'd3, 1'b0, 1'b0, 1'b1);
    step(4'd6, 32'h8000_0000, 32'd1, 1'b1, 1'b0, 1'b1);
    // R3: reverse forms
    step(4'd3, 32'd3, 32'd5, 1'b0, 1'b0, 1'b1);
    step(4'd7, 32'd5, 32'd3, 1'b0, 1'b0, 1'b1);
    // R7: no set_flags, flags hold
    step(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
    step(4'd13, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0);
    // R6: compare/test update with set_flags low
    step(4'd10, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0);
    step(4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);
    step(4'd8, 32'hFF00, 32'h00FF, 1'b0, 1'b1, 1'b0);
    step(4'd9, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b0);
    // R4, R5
    step(4'd1, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b0, 1'b1);
    step(4'd12, 32'h1200_0000, 32'h0000_0034, 1'b0, 1'b1, 1'b1);
    step(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1);
    step(4'd15, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b1);
    step(4'd13, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) rb = ra;
      step(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule